// File: doc/BRIEF.md
# Low-Rate Reference Edge Noise Window

This block sits between the edge detector of a low-rate reference clock (nominally 2, 4 or 8 kHz) and the phase detector of a DPLL. It counts system-clock cycles from the last trusted edge. It then accepts only an edge that arrives within a narrow band centred on the position where the next edge is expected. The band covers 5% of the nominal period, so it reaches half of that on each side of the prediction. An edge outside the band is treated as noise: it is dropped, a one-cycle reject strobe is raised, and a saturating counter of such edges advances.

Filtering takes place only when three conditions hold together: the enable input is set, the loop reports lock, and the rate select names one of the three low rates. In every other case each incoming edge is forwarded unchanged. Each period and half-band length, counted in system-clock cycles, is a parameter. The defaults assume a 32.768 MHz system clock: 16384, 8192 and 4096 cycles for the period, and 410, 205 and 102 cycles for the half-band.

Top module: `edge_noise_window`

## Requirements
- R1: With `rate_sel` = 3 (not a low rate), every `edge_in` pulse gives an `edge_ok` pulse one cycle later, whatever the values of `win_en` and `locked`.
- R2: While filtering, an edge that arrives d cycles after the anchor, with PERIOD−HALF ≤ d ≤ PERIOD+HALF for the selected rate, is accepted. The rate codes are 0 = 2 kHz, 1 = 4 kHz and 2 = 8 kHz.
- R3: While filtering, an edge outside that band gives an `edge_rej` pulse one cycle later and no `edge_ok` pulse.
- R4: With `win_en` = 0, every edge is accepted.
- R5: With `locked` = 0, every edge is accepted, even when `win_en` = 1.
- R6: The first edge after filtering becomes active is always accepted and becomes the anchor.
- R7: Each accepted edge becomes the new anchor for the following band.
- R8: If no edge has been accepted by anchor+PERIOD+HALF, the anchor moves forward by exactly PERIOD, so the filter coasts past a missing edge.
- R9: `rej_count` rises by one in the same cycle as each `edge_rej` pulse and holds at 255. Reset clears it to 0.
- R10: `edge_ok` and `edge_rej` are registered and never high together, and both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_in | input | 1 | One-cycle strobe per reference edge |
| rate_sel | input | 2 | 0 = 2 kHz, 1 = 4 kHz, 2 = 8 kHz, 3 = other rate |
| win_en | input | 1 | Enables the noise window |
| locked | input | 1 | DPLL lock indication |
| edge_ok | output | 1 | Qualified edge strobe for the phase detector |
| edge_rej | output | 1 | Strobe for an edge dropped as noise |
| rej_count | output | 8 | Saturating count of dropped edges |

## Verification
The hardest case to reach is the coasting re-anchor. It needs the filter to be active, anchored, and then to receive no edge up to the last cycle of the band. A later edge must then land at a gap that is wrong against the old anchor and right against the coasted one. The bench reaches this by using small period parameters and placing edges at exact gaps: one gap one cycle past the band's end, then one chosen so that it is accepted only if the anchor moved by exactly one period. Saturation of the counter is reached by driving a dense train of edges while the filter is active.

// File: rtl/enw_pkg.sv
// Shared types for the edge noise window.
package enw_pkg;
    typedef enum logic [1:0] {
        RATE_2K    = 2'd0,
        RATE_4K    = 2'd1,
        RATE_8K    = 2'd2,
        RATE_OTHER = 2'd3
    } rate_e;
endpackage

// File: rtl/enw_rate_table.sv
// Maps the rate select to a nominal period and half-band length in
// system-clock cycles. Assumes every parameter fits in CNT_W bits.
module enw_rate_table #(
    parameter int CNT_W  = 16,
    parameter int PER_2K = 16384,
    parameter int PER_4K = 8192,
    parameter int PER_8K = 4096,
    parameter int HW_2K  = 410,
    parameter int HW_4K  = 205,
    parameter int HW_8K  = 102
) (
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] half_win,
    output logic             low_rate
);
    import enw_pkg::*;

    // Lookup of period and half-band for the selected rate.
    always_comb begin
        low_rate = 1'b1;
        unique case (rate_e'(rate_sel))
            RATE_2K: begin period = CNT_W'(PER_2K); half_win = CNT_W'(HW_2K); end
            RATE_4K: begin period = CNT_W'(PER_4K); half_win = CNT_W'(HW_4K); end
            RATE_8K: begin period = CNT_W'(PER_8K); half_win = CNT_W'(HW_8K); end
            default: begin
                period   = '0;
                half_win = '0;
                low_rate = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/enw_edge_timer.sv
// Tracks the cycles since the current anchor and flags when the present
// cycle lies inside the acceptance band. It re-anchors on an accepted
// edge and coasts by one period once the band has closed.
// Assumes period > half_win and that the incoming edge is a one-cycle strobe.
module enw_edge_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             edge_in,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] half_win,
    output logic             anchored,
    output logic             in_band
);
    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] band_lo;
    logic [CNT_W-1:0] band_hi;
    logic             accept;

    // Band edges and the accept decision for this cycle.
    always_comb begin
        band_lo = period - half_win;
        band_hi = period + half_win;
        in_band = (since_q >= band_lo) && (since_q <= band_hi);
        accept  = edge_in && (!anchored || in_band);
    end

    // Anchor state and elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            anchored <= 1'b0;
            since_q  <= '0;
        end else if (accept) begin
            anchored <= 1'b1;
            since_q  <= CNT_W'(1);
        end else if (anchored && since_q >= band_hi) begin
            since_q  <= since_q + CNT_W'(1) - period;
        end else if (anchored) begin
            since_q  <= since_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/enw_reject_counter.sv
// Saturating counter of dropped edges. It advances once per reject request.
module enw_reject_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = '1;

    // Increment and hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + CW'(1);
    end
endmodule

// File: rtl/edge_noise_window.sv
// Noise window filter for low-rate reference edges ahead of a DPLL phase
// detector. It forwards in-band edges and drops the rest, but only while
// enabled, locked and set to a low rate; otherwise every edge passes.
// Assumes edge_in is already synchronised and one cycle wide.
module edge_noise_window #(
    parameter int PER_2K = 16384,
    parameter int PER_4K = 8192,
    parameter int PER_8K = 4096,
    parameter int HW_2K  = 410,
    parameter int HW_4K  = 205,
    parameter int HW_8K  = 102,
    parameter int REJ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_in,
    input  logic [1:0]       rate_sel,
    input  logic             win_en,
    input  logic             locked,
    output logic             edge_ok,
    output logic             edge_rej,
    output logic [REJ_W-1:0] rej_count
);
    localparam int MAX_P = (PER_2K > PER_4K) ? ((PER_2K > PER_8K) ? PER_2K : PER_8K)
                                             : ((PER_4K > PER_8K) ? PER_4K : PER_8K);
    localparam int MAX_H = (HW_2K > HW_4K) ? ((HW_2K > HW_8K) ? HW_2K : HW_8K)
                                           : ((HW_4K > HW_8K) ? HW_4K : HW_8K);
    localparam int CNT_W = $clog2(MAX_P + MAX_H + 2) + 1;

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half_win;
    logic             low_rate;
    logic             active;
    logic             anchored;
    logic             in_band;
    logic             drop;

    enw_rate_table #(
        .CNT_W(CNT_W), .PER_2K(PER_2K), .PER_4K(PER_4K), .PER_8K(PER_8K),
        .HW_2K(HW_2K), .HW_4K(HW_4K), .HW_8K(HW_8K)
    ) table_i (
        .rate_sel(rate_sel), .period(period), .half_win(half_win), .low_rate(low_rate)
    );

    // Filtering is active only when enabled, locked and at a low rate.
    always_comb begin
        active = win_en && locked && low_rate;
        drop   = edge_in && active && anchored && !in_band;
    end

    enw_edge_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .active(active), .edge_in(edge_in),
        .period(period), .half_win(half_win), .anchored(anchored), .in_band(in_band)
    );

    enw_reject_counter #(.CW(REJ_W)) rejcnt_i (
        .clk(clk), .rst_n(rst_n), .inc(drop), .count(rej_count)
    );

    // Registered output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_ok  <= 1'b0;
            edge_rej <= 1'b0;
        end else begin
            edge_ok  <= edge_in && !drop;
            edge_rej <= drop;
        end
    end
endmodule

// File: rtl/edge_noise_window_chk.sv
// Port-level properties of the edge noise window, attached by bind.
module edge_noise_window_chk #(
    parameter int REJ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_in,
    input logic [1:0]       rate_sel,
    input logic             win_en,
    input logic             locked,
    input logic             edge_ok,
    input logic             edge_rej,
    input logic [REJ_W-1:0] rej_count
);
    localparam logic [REJ_W-1:0] TOP = '1;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(edge_ok && edge_rej)); // R10

    AST_NO_EDGE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_in |=> (!edge_ok && !edge_rej)); // R10

    AST_OTHER_RATE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_in && rate_sel == 2'd3) |=> edge_ok); // R1

    AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_in && !win_en) |=> edge_ok); // R4

    AST_UNLOCKED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_in && !locked) |=> edge_ok); // R5

    AST_REJECT_ONLY_FILTERING: assert property (@(posedge clk) disable iff (!rst_n)
        edge_rej |-> $past(win_en && locked && rate_sel != 2'd3)); // R3

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rej && $past(rej_count) != TOP) |-> rej_count == $past(rej_count) + REJ_W'(1)); // R9

    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        rej_count == TOP |=> rej_count == TOP); // R9
endmodule

bind edge_noise_window edge_noise_window_chk #(.REJ_W(REJ_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .rate_sel(rate_sel),
    .win_en(win_en), .locked(locked), .edge_ok(edge_ok),
    .edge_rej(edge_rej), .rej_count(rej_count)
);

// File: tb/edge_noise_window_tb_top.sv
// Bench for edge_noise_window. A behavioural model, which keeps the anchor
// as an absolute cycle number, predicts the outputs and is compared every cycle.
module edge_noise_window_tb_top;
    localparam int P0 = 200, H0 = 10;
    localparam int P1 = 120, H1 = 6;
    localparam int P2 = 60,  H2 = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge_in = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       win_en = 1'b0;
    logic       locked = 1'b0;
    logic       edge_ok;
    logic       edge_rej;
    logic [7:0] rej_count;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    edge_noise_window #(
        .PER_2K(P0), .PER_4K(P1), .PER_8K(P2),
        .HW_2K(H0), .HW_4K(H1), .HW_8K(H2), .REJ_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .edge_in(edge_in), .rate_sel(rate_sel),
        .win_en(win_en), .locked(locked), .edge_ok(edge_ok),
        .edge_rej(edge_rej), .rej_count(rej_count)
    );

    always #5 clk = ~clk;

    // Reference model state.
    longint now = 0;
    longint anchor_at = 0;
    bit     has_anchor = 1'b0;
    bit     exp_ok = 1'b0;
    bit     exp_rej = 1'b0;
    int     exp_cnt = 0;

    function automatic int per_of(input logic [1:0] r);
        return (r == 2'd0) ? P0 : (r == 2'd1) ? P1 : P2;
    endfunction
    function automatic int half_of(input logic [1:0] r);
        return (r == 2'd0) ? H0 : (r == 2'd1) ? H1 : H2;
    endfunction

    // Model step at each rising edge, from the inputs applied one half-cycle earlier.
    always @(posedge clk) begin
        longint gap;
        int     p;
        int     h;
        now++;
        exp_ok  = 1'b0;
        exp_rej = 1'b0;
        if (!rst_n) begin
            has_anchor = 1'b0;
            exp_cnt    = 0;
        end else if (!(win_en && locked && rate_sel != 2'd3)) begin
            has_anchor = 1'b0;        // R1 R4 R5: everything passes
            exp_ok     = edge_in;
        end else if (!has_anchor) begin
            if (edge_in) begin        // R6
                exp_ok     = 1'b1;
                has_anchor = 1'b1;
                anchor_at  = now;
            end
        end else begin
            p   = per_of(rate_sel);
            h   = half_of(rate_sel);
            gap = now - anchor_at;
            if (edge_in && gap >= p - h && gap <= p + h) begin
                exp_ok    = 1'b1;     // R2 R7
                anchor_at = now;
            end else begin
                if (edge_in) begin    // R3 R9
                    exp_rej = 1'b1;
                    if (exp_cnt < 255) exp_cnt++;
                end
                if (gap >= p + h) anchor_at = anchor_at + p;   // R8
            end
        end
    end

    task automatic check_bit(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", cur_req, what, act, exp);
        end
    endtask

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check_bit("edge_ok", edge_ok, exp_ok);
            check_bit("edge_rej", edge_rej, exp_rej);
            check_bit("excl", edge_ok && edge_rej, 1'b0);   // R10
            checks++;
            if (rej_count !== 8'(exp_cnt)) begin            // R9
                failures++;
                $display("FAIL %s rej_count actual=%0d expected=%0d", cur_req, rej_count, exp_cnt);
            end
        end
    end

    // Wait gap-1 cycles, then drive a one-cycle edge strobe.
    task automatic fire_gap(input int gap);
        repeat (gap - 1) @(negedge clk);
        edge_in = 1'b1;
        @(negedge clk);
        edge_in = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] r, input logic en, input logic lk);
        @(negedge clk);
        rate_sel = r;
        win_en   = en;
        locked   = lk;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";              // reset state
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R1";
        set_mode(2'd3, 1'b1, 1'b1);
        fire_gap(3); fire_gap(7); fire_gap(1); fire_gap(50);

        cur_req = "R4";
        set_mode(2'd0, 1'b0, 1'b1);
        fire_gap(4); fire_gap(9); fire_gap(33);

        cur_req = "R5";
        set_mode(2'd1, 1'b1, 1'b0);
        fire_gap(5); fire_gap(2); fire_gap(77);

        cur_req = "R6";
        set_mode(2'd0, 1'b1, 1'b1);
        fire_gap(5);                  // first edge anchors
        cur_req = "R2";
        fire_gap(P0);
        fire_gap(P0 - H0);
        fire_gap(P0 + H0);
        cur_req = "R3";
        fire_gap(P0 - H0 - 1);        // early: dropped
        cur_req = "R7";
        fire_gap(H0 + 1);             // lands at P0 from the kept anchor
        fire_gap(P0);
        cur_req = "R8";
        fire_gap(P0 + H0 + 1);        // just late: dropped, anchor coasted
        fire_gap(P0 - H0 - 1);        // matches only the coasted anchor
        fire_gap(3 * P0);             // two missing edges coasted over

        cur_req = "R5";
        set_mode(2'd0, 1'b1, 1'b0);
        fire_gap(7);
        cur_req = "R6";
        set_mode(2'd0, 1'b1, 1'b1);
        fire_gap(13); fire_gap(40);

        cur_req = "R2";
        set_mode(2'd1, 1'b1, 1'b1);
        fire_gap(9); fire_gap(P1 - H1); fire_gap(P1 + H1); fire_gap(P1 + H1 + 1);
        set_mode(2'd2, 1'b1, 1'b1);
        fire_gap(2); fire_gap(P2); fire_gap(P2 - H2 - 1); fire_gap(H2 + 1);

        cur_req = "R9";
        for (int i = 0; i < 700; i++) fire_gap(2);
        set_mode(2'd2, 1'b0, 1'b1);
        fire_gap(3);
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule